// File: doc/BRIEF.md
# Low-Address Protection Checker

This block sits next to an address translation unit and decides, for each access it is handed, whether low-address protection refuses a store. Two disjoint windows of 512 bytes are guarded: one at the start of page 0 and one at the start of page 1. Protection is governed by a global enable. When address translation is off and the enable is set, protection always applies. When translation is on, each of the three address spaces (primary, secondary, home) has its own private-space bit, and a set bit exempts that space from protection.

Besides refusing a store, the block tells the translation unit whether the page holding the access must be flagged so that any cached write permission is checked again on each later access. A refused store also raises a protection exception request, whose exception code is zero. The access-register address-space mode is not supported. Selecting it with translation on raises an error output and leaves protection off. All decisions are combinational and are presented through one registered stage, one cycle after the request.

Top module: `lap_checker`

## Requirements
- R1: An exact address is protected when it lies in 0..511 or in 4096..4607; addresses such as 512, 4095, 4608 and 8192 are not protected.
- R2: When `prot_en` is 0, `block_store`, `recheck_wr` and `prot_exc_req` stay 0 for every access.
- R3: When `prot_en` is 1 and `xlate_on` is 0, protection applies whatever the private-space bits and the space mode are.
- R4: When `xlate_on` is 1, protection applies only if the private-space bit of the selected space is 0. Space mode encoding: 0 primary (`priv_bits[0]`), 2 secondary (`priv_bits[1]`), 3 home (`priv_bits[2]`).
- R5: Space mode 1 (access register) with `xlate_on` = 1 sets `mode_err` and disables protection; with `xlate_on` = 0 it has no effect.
- R6: While protection applies, `recheck_wr` is 1 for any access type whose page base (address with its low 12 bits cleared) is 0 or 4096, so 0..8191.
- R7: A store (access type 1) to a protected exact address while protection applies sets `block_store` and `prot_exc_req`, with `exc_code` equal to 0.
- R8: Reads (access type 0) and instruction fetches (access type 2) are never blocked and never raise the exception.
- R9: Results appear with `out_valid` on the cycle after `in_valid`. Every output is 0 after reset and in any cycle that follows a cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Access request present this cycle |
| addr | input | ADDR_W | Logical or real byte address |
| acc_type | input | 2 | 0 read, 1 store, 2 fetch |
| prot_en | input | 1 | Global low-address protection enable |
| xlate_on | input | 1 | Address translation is on |
| space_mode | input | 2 | 0 primary, 1 access register, 2 secondary, 3 home |
| priv_bits | input | 3 | Private-space bits: [0] primary, [1] secondary, [2] home |
| out_valid | output | 1 | Registered results are valid |
| block_store | output | 1 | Store refused by protection |
| recheck_wr | output | 1 | Page must have writes rechecked on each access |
| prot_exc_req | output | 1 | Protection exception request |
| exc_code | output | EXC_W | Exception code that goes with the request (zero) |
| mode_err | output | 1 | Unsupported address-space mode selected |

## Verification
The bench walks the edges of both windows (511/512, 4095/4096, 4607/4608, 8191/8192). A design that merged the windows, or that was off by one at an edge, would block a store at 512 or 4608, or would miss one at 4607. Two cases separate the exact-address test from the page-base test: address 512 must set the recheck flag without blocking, and address 4095 must do the same. A design that used one test for both jobs would either block these stores or fail to flag the page. The private-space bits are tried in complementary patterns for each space, so reading the wrong space's bit shows up. Further cases cover translation off with every private bit set, and the access-register mode with translation both on and off, which catch a design that consults the private bits when translation is off, or that raises the mode error when translation is off.

// File: rtl/lap_pkg.sv
package lap_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SPC_PRIMARY   = 2'd0,
    SPC_ACCREG    = 2'd1,
    SPC_SECONDARY = 2'd2,
    SPC_HOME      = 2'd3
  } space_e;

  localparam int unsigned NUM_SPACES = 3;

  typedef struct packed {
    logic blk;
    logic rchk;
    logic exc;
    logic err;
  } lap_res_t;

endpackage

// File: rtl/lap_window_match.sv
module lap_window_match #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WIN_BYTES = 512,
  parameter int unsigned NUM_WIN   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  logic [NUM_WIN-1:0] hit_vec;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(k) << PAGE_BITS;
    localparam logic [ADDR_W-1:0] LIMIT = BASE + ADDR_W'(WIN_BYTES);
    assign hit_vec[k] = (addr >= BASE) && (addr < LIMIT);
  end

  assign hit = |hit_vec;

  // R1: the guarded windows never overlap
  always_comb begin
    a_r1_windows_disjoint: assert ($onehot0(hit_vec))
      else $error("protected windows overlap");
  end

endmodule

// File: rtl/lap_enable_sel.sv
module lap_enable_sel
  import lap_pkg::*;
(
  input  logic                  prot_en,
  input  logic                  xlate_on,
  input  logic [1:0]            space_mode,
  input  logic [NUM_SPACES-1:0] priv_bits,
  output logic                  prot_active,
  output logic                  mode_err
);

  space_e spc;
  logic   priv_sel;
  logic   spc_ok;

  assign spc = space_e'(space_mode);

  always_comb begin
    priv_sel = 1'b1;
    spc_ok   = 1'b1;
    unique case (spc)
      SPC_PRIMARY:   priv_sel = priv_bits[0];
      SPC_SECONDARY: priv_sel = priv_bits[1];
      SPC_HOME:      priv_sel = priv_bits[2];
      SPC_ACCREG: begin
        priv_sel = 1'b1;
        spc_ok   = 1'b0;
      end
      default: begin
        priv_sel = 1'b1;
        spc_ok   = 1'b0;
      end
    endcase
  end

  assign mode_err    = xlate_on && !spc_ok;
  assign prot_active = prot_en && (!xlate_on || (spc_ok && !priv_sel));

endmodule

// File: rtl/lap_out_reg.sv
module lap_out_reg
  import lap_pkg::*;
#(
  parameter int unsigned EXC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  lap_res_t         res_d,
  output logic             out_valid,
  output lap_res_t         res_q,
  output logic [EXC_W-1:0] code_q
);

  logic             valid_nx;
  lap_res_t         res_nx;
  logic [EXC_W-1:0] code_nx;

  always_comb begin
    valid_nx = in_valid;
    res_nx   = in_valid ? res_d : '0;
    code_nx  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      code_q    <= '0;
    end else begin
      out_valid <= valid_nx;
      res_q     <= res_nx;
      code_q    <= code_nx;
    end
  end

  // R9: output valid follows the request by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && res_q == '0));

endmodule

// File: rtl/lap_checker.sv
module lap_checker
  import lap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WIN_BYTES = 512,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned EXC_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_type,
  input  logic              prot_en,
  input  logic              xlate_on,
  input  logic [1:0]        space_mode,
  input  logic [2:0]        priv_bits,
  output logic              out_valid,
  output logic              block_store,
  output logic              recheck_wr,
  output logic              prot_exc_req,
  output logic [EXC_W-1:0]  exc_code,
  output logic              mode_err
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] page_base;
  logic              exact_hit;
  logic              page_hit;
  logic              prot_active;
  logic              err_c;
  logic              is_store;
  lap_res_t          res_d;
  lap_res_t          res_q;

  assign page_base = addr & PAGE_MASK;
  assign is_store  = (acc_e'(acc_type) == ACC_STORE);

  lap_window_match #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .WIN_BYTES(WIN_BYTES), .NUM_WIN(NUM_WIN)
  ) exact_i (
    .addr (addr),
    .hit  (exact_hit)
  );

  lap_window_match #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .WIN_BYTES(WIN_BYTES), .NUM_WIN(NUM_WIN)
  ) page_i (
    .addr (page_base),
    .hit  (page_hit)
  );

  lap_enable_sel enable_i (
    .prot_en     (prot_en),
    .xlate_on    (xlate_on),
    .space_mode  (space_mode),
    .priv_bits   (priv_bits),
    .prot_active (prot_active),
    .mode_err    (err_c)
  );

  always_comb begin
    res_d.rchk = prot_active && page_hit;
    res_d.blk  = prot_active && exact_hit && is_store;
    res_d.exc  = prot_active && exact_hit && is_store;
    res_d.err  = err_c;
  end

  lap_out_reg #(.EXC_W(EXC_W)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_d     (res_d),
    .out_valid (out_valid),
    .res_q     (res_q),
    .code_q    (exc_code)
  );

  assign block_store  = res_q.blk;
  assign recheck_wr   = res_q.rchk;
  assign prot_exc_req = res_q.exc;
  assign mode_err     = res_q.err;

  // R6: a protected exact address always lies in a flagged page
  always_comb begin
    a_r6_exact_in_page: assert (!exact_hit || page_hit)
      else $error("exact hit outside flagged page");
  end

  // R2: global enable clear keeps everything quiet
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prot_en) |=> (!block_store && !recheck_wr && !prot_exc_req));

  // R8: reads and fetches never blocked
  a_r8_no_block_nonstore: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_type != 2'd1) |=> (!block_store && !prot_exc_req));

  // R5: access-register mode with translation on errors and disables
  a_r5_accreg_err: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && xlate_on && space_mode == 2'd1) |=> (mode_err && !block_store && !recheck_wr));

  // R7: a refused store carries the exception with zero code
  a_r7_block_has_exc: assert property (@(posedge clk) disable iff (!rst_n)
    block_store |-> (prot_exc_req && exc_code == '0 && out_valid));

  // R6: a refused store's page is flagged for recheck
  a_r6_block_implies_recheck: assert property (@(posedge clk) disable iff (!rst_n)
    block_store |-> recheck_wr);

endmodule

// File: tb/lap_checker_tb_top.sv
module lap_checker_tb_top;

  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  acc;
    logic        en;
    logic        xl;
    logic [1:0]  mode;
    logic [2:0]  priv;
    logic        eb;
    logic        er;
    logic        ee;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // fields: addr, acc(0 rd,1 st,2 fe), en, xlate, mode(0 P,1 AR,2 S,3 H), priv, blk, rchk, err, req
  localparam vec_t VECS [NV] = '{
    '{64'd0,     2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b1, 1'b0, 4'd1}, // R1 low edge
    '{64'd511,   2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b1, 1'b0, 4'd1}, // R1 top of window 0
    '{64'd512,   2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 flagged not blocked
    '{64'd4096,  2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b1, 1'b0, 4'd1}, // R1 window 1 start
    '{64'd4607,  2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 window 1 end
    '{64'd4608,  2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd6}, // R6
    '{64'd8192,  2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 beyond page 1
    '{64'd4095,  2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 gap
    '{64'd0,     2'd0, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 read
    '{64'd100,   2'd2, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 fetch
    '{64'd0,     2'd1, 1'b0, 1'b0, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
    '{64'd0,     2'd1, 1'b1, 1'b0, 2'd0, 3'b111, 1'b1, 1'b1, 1'b0, 4'd3}, // R3 private ignored
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd0, 3'b001, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 primary private
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd0, 3'b110, 1'b1, 1'b1, 1'b0, 4'd4}, // R4 primary open
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd2, 3'b010, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 secondary private
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd2, 3'b101, 1'b1, 1'b1, 1'b0, 4'd4}, // R4 secondary open
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd3, 3'b100, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 home private
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd3, 3'b011, 1'b1, 1'b1, 1'b0, 4'd4}, // R4 home open
    '{64'd0,     2'd1, 1'b1, 1'b1, 2'd1, 3'b000, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 AR xlate on
    '{64'd0,     2'd1, 1'b0, 1'b1, 2'd1, 3'b000, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 AR, enable off
    '{64'd0,     2'd1, 1'b1, 1'b0, 2'd1, 3'b000, 1'b1, 1'b1, 1'b0, 4'd5}, // R5 AR xlate off
    '{64'h1_0000_0000, 2'd1, 1'b1, 1'b0, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 4'd1} // R1 high
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] addr;
  logic [1:0]  acc_type;
  logic        prot_en;
  logic        xlate_on;
  logic [1:0]  space_mode;
  logic [2:0]  priv_bits;
  logic        out_valid;
  logic        block_store;
  logic        recheck_wr;
  logic        prot_exc_req;
  logic [15:0] exc_code;
  logic        mode_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  lap_checker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr),
    .acc_type(acc_type), .prot_en(prot_en), .xlate_on(xlate_on),
    .space_mode(space_mode), .priv_bits(priv_bits), .out_valid(out_valid),
    .block_store(block_store), .recheck_wr(recheck_wr),
    .prot_exc_req(prot_exc_req), .exc_code(exc_code), .mode_err(mode_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    addr       = v.addr;
    acc_type   = v.acc;
    prot_en    = v.en;
    xlate_on   = v.xl;
    space_mode = v.mode;
    priv_bits  = v.priv;
  endtask

  initial begin
    string tag;
    rst_n = 1'b0; in_valid = 1'b0; addr = '0; acc_type = '0;
    prot_en = 1'b0; xlate_on = 1'b0; space_mode = '0; priv_bits = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R9", "reset outputs", {59'd0, block_store, recheck_wr, prot_exc_req, mode_err, |exc_code}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      tag = $sformatf("R%0d#%0d", VECS[i].req, i);
      chk(tag, "out_valid", 64'(out_valid), 64'd1);
      chk(tag, "block_store", 64'(block_store), 64'(VECS[i].eb));
      chk(tag, "recheck_wr", 64'(recheck_wr), 64'(VECS[i].er));
      chk(tag, "prot_exc_req", 64'(prot_exc_req), 64'(VECS[i].eb)); // R7
      chk(tag, "mode_err", 64'(mode_err), 64'(VECS[i].ee));
      chk(tag, "exc_code", 64'(exc_code), 64'd0);
    end

    // R9: dropping in_valid clears outputs on the next cycle
    drive(VECS[0]);
    @(negedge clk);
    chk("R9", "blocked before idle", 64'(block_store), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9", "idle out_valid", 64'(out_valid), 64'd0);
    chk("R9", "idle block_store", 64'(block_store), 64'd0);
    chk("R9", "idle recheck_wr", 64'(recheck_wr), 64'd0);

    // R9: result not visible before the clock edge
    drive(VECS[0]);
    #1;
    chk("R9", "no early out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R9", "out_valid after edge", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule